// File: doc/BRIEF.md
# Audio Link Global Control, Status and Codec Semaphore

This block holds the global control word and the global status word of an audio link controller, and a one-bit semaphore that serialises software access to codec registers. The control word drives the codec link's cold reset (held while its release bit is clear) and a warm reset that runs for a fixed number of cycles and then clears its own bit. It also holds the link shut-off, the channel-count and sample-width selections and the interrupt enables.

The status word shows three kinds of flag. Codec-ready flags for three serial inputs are shown only once cold reset is released. Sticky resume flags and a sticky read-completion flag are cleared by writing one to them. The live interrupt flags of the DMA channels and the capability bits come straight from inputs and parameters. The semaphore is claimed by reading it: the read returns the current bit and leaves it set. A codec-access-done pulse or a cold reset clears it.

Software reaches the block through a plain register port. A strobe with the write flag low is a read; its data appears with `host_rvalid` in the next cycle. There is no back-pressure: every strobe is taken in the cycle it is presented. Offsets are 0x2C (control), 0x30 (status) and 0x34 (semaphore). Other offsets ignore writes and read as zero.

Top module: `alink_global`

## Requirements
- R1: After reset the control word reads 0, `cold_rst_n`, `warm_rst` and `irq` are low, the semaphore reads 0 and the status word shows only the capability bits (bit 20 = `CAP_4CH`, bit 21 = `CAP_6CH`) and live channel flags.
- R2: `cold_rst_n` equals control bit 1. Writing bit 1 as 0 reasserts cold reset, aborts a running warm reset and clears the semaphore.
- R3: Status bits 8, 9 and 28 show `codec_ready[0]`, `[1]` and `[2]` only while cold reset is released, and read 0 otherwise. Resume pulses on `resume_evt[0..2]` set status bits 10, 11 and 29 only while released.
- R4: Status bits 10, 11, 29 (resume) and 15 (read completion, set by `rd_done`) are cleared by writing 1 to them at 0x30. A set pulse in the same cycle as the clear wins.
- R5: Writing 1 to control bit 2 while cold reset is already released raises `warm_rst` and bit 2 for exactly `WARM_CYCLES` cycles, after which both clear. The same write is ignored while cold reset is asserted, and writing bit 2 as 0 has no effect.
- R6: Control bits 21:20 select 2 (0), 4 (1) or 6 (2) channels on `chan_cfg`. A write carrying code 3 leaves the field unchanged. Bit 22 selects 20-bit samples on `wide_samples`. Bit 23 always reads 0.
- R7: Control bit 3 drives `link_off`. Bits 0 and 6:4 read back as written.
- R8: Status bits 7, 6, 5, 2, 1, 0 show `chan_irq[5]` to `chan_irq[0]` (mic-in, PCM-out, PCM-in, modem-out, modem-in, GPI change) live.
- R9: A read of 0x34 returns bit 0 as it was and leaves it 1 while cold reset is released. An `acc_done` pulse clears it, and a read taking place in the same cycle as `acc_done` on a held semaphore returns 1 and leaves it clear. While cold reset is asserted it reads 0 and cannot be taken.
- R10: `irq` is high when any of `chan_irq[5:1]` is high, when `chan_irq[0]` is high with control bit 0 set, or when a resume flag is set with its enable (control bit 4, 5 or 6 for inputs 0, 1, 2) set.
- R11: Read data is valid with `host_rvalid` one cycle after the strobe. Writes to other offsets change nothing, and reads of them return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel | input | 1 | Register access strobe |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Byte offset |
| host_wdata | input | 32 | Write data |
| host_rvalid | output | 1 | Read data valid |
| host_rdata | output | 32 | Read data |
| codec_ready | input | 3 | Codec-ready level per serial input |
| resume_evt | input | 3 | Resume event pulse per serial input |
| rd_done | input | 1 | Codec read completion pulse |
| acc_done | input | 1 | Codec access finished pulse |
| chan_irq | input | 6 | Live channel interrupt flags |
| cold_rst_n | output | 1 | Codec link cold reset, active low |
| warm_rst | output | 1 | Codec link warm reset, active high |
| link_off | output | 1 | Link shut-off |
| chan_cfg | output | 2 | Channel-count selection |
| wide_samples | output | 1 | 20-bit sample selection |
| irq | output | 1 | Aggregated interrupt |

## Verification
The bench probes ordering collisions. It writes one to clear a resume flag in the same cycle as a new pulse, which a design giving the clear priority would lose. It reads the semaphore in the same cycle as the done pulse, which a design checking the pulse after the claim would leave stuck. It asks for a warm reset while cold reset is held, where a careless design would pulse the link anyway. It also counts the exact width of the warm pulse, sends the reserved channel code, and checks that codec-ready and resume flags stay hidden while cold reset is held, which a design without the gating would show too early.

// File: rtl/alink_pkg.sv
package alink_pkg;
  localparam logic [7:0] OFS_CTL = 8'h2C;
  localparam logic [7:0] OFS_STA = 8'h30;
  localparam logic [7:0] OFS_SEM = 8'h34;

  // status bit positions
  localparam int B_RDY0 = 8;
  localparam int B_RDY1 = 9;
  localparam int B_RDY2 = 28;
  localparam int B_RSM0 = 10;
  localparam int B_RSM1 = 11;
  localparam int B_RSM2 = 29;
  localparam int B_RCS  = 15;
  localparam int B_CAP4 = 20;
  localparam int B_CAP6 = 21;

  localparam logic [1:0] CHAN_RSVD = 2'd3;

  typedef struct packed {
    logic       wide;
    logic [1:0] chan;
    logic [2:0] resume_en;
    logic       link_off;
    logic       warm;
    logic       cold_rel;
    logic       gpi_en;
  } ctl_t;
endpackage

// File: rtl/alink_ctl_reg.sv
module alink_ctl_reg
  import alink_pkg::*;
#(
  parameter int WARM_CYCLES = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_ctl,
  input  logic [22:0] wdata,
  output ctl_t        ctl_q
);
  localparam int CW = (WARM_CYCLES > 1) ? $clog2(WARM_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(WARM_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic          cold_next;

  assign cold_next = wr_ctl ? wdata[1] : ctl_q.cold_rel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q <= '0;
      cnt_q <= '0;
    end else begin
      if (wr_ctl) begin
        ctl_q.gpi_en    <= wdata[0];
        ctl_q.cold_rel  <= wdata[1];
        ctl_q.link_off  <= wdata[3];
        ctl_q.resume_en <= wdata[6:4];
        ctl_q.wide      <= wdata[22];
        if (wdata[21:20] != CHAN_RSVD) ctl_q.chan <= wdata[21:20];
      end
      if (!cold_next) begin
        ctl_q.warm <= 1'b0;
        cnt_q      <= '0;
      end else if (wr_ctl && wdata[2] && ctl_q.cold_rel && !ctl_q.warm) begin
        ctl_q.warm <= 1'b1;
        cnt_q      <= '0;
      end else if (ctl_q.warm) begin
        if (cnt_q == LAST) ctl_q.warm <= 1'b0;
        else               cnt_q      <= cnt_q + 1'b1;
      end
    end
  end

  p_cold_kills_warm_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_q.cold_rel |-> !ctl_q.warm);
  p_warm_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q.warm |-> (int'(cnt_q) < WARM_CYCLES));
  p_warm_needs_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl_q.warm) |-> $past(ctl_q.cold_rel));
endmodule

// File: rtl/alink_stat_reg.sv
module alink_stat_reg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cold_rel,
  input  logic [2:0] resume_evt,
  input  logic       rd_done,
  input  logic       clr_wr,
  input  logic [2:0] clr_resume,
  input  logic       clr_rcs,
  output logic [2:0] resume_q,
  output logic       rcs_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resume_q <= '0;
      rcs_q    <= 1'b0;
    end else begin
      for (int k = 0; k < 3; k++) begin
        if (cold_rel && resume_evt[k])    resume_q[k] <= 1'b1;
        else if (clr_wr && clr_resume[k]) resume_q[k] <= 1'b0;
      end
      if (cold_rel && rd_done)     rcs_q <= 1'b1;
      else if (clr_wr && clr_rcs)  rcs_q <= 1'b0;
    end
  end

  p_resume_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|(resume_q & ~$past(resume_q))) |-> $past(cold_rel));
  p_rcs_w1c_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && clr_rcs && !rd_done) |=> !rcs_q);
  p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cold_rel && rd_done) |=> rcs_q);
endmodule

// File: rtl/alink_sem.sv
module alink_sem (
  input  logic clk,
  input  logic rst_n,
  input  logic cold_rel,
  input  logic claim,
  input  logic acc_done,
  output logic sem_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)                    sem_q <= 1'b0;
    else if (!cold_rel)            sem_q <= 1'b0;
    else if (claim && !sem_q)      sem_q <= 1'b1;
    else if (acc_done)             sem_q <= 1'b0;
  end

  p_sem_take_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (claim && !sem_q && cold_rel) |=> sem_q);
  p_sem_cold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cold_rel |=> !sem_q);
  p_sem_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sem_q && acc_done) |=> !sem_q);
endmodule

// File: rtl/alink_global.sv
module alink_global
  import alink_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int WARM_CYCLES = 16,
  parameter bit CAP_4CH     = 1'b1,
  parameter bit CAP_6CH     = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_sel,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [31:0]       host_wdata,
  output logic              host_rvalid,
  output logic [31:0]       host_rdata,
  input  logic [2:0]        codec_ready,
  input  logic [2:0]        resume_evt,
  input  logic              rd_done,
  input  logic              acc_done,
  input  logic [5:0]        chan_irq,
  output logic              cold_rst_n,
  output logic              warm_rst,
  output logic              link_off,
  output logic [1:0]        chan_cfg,
  output logic              wide_samples,
  output logic              irq
);
  logic hit_ctl, hit_sta, hit_sem, rd_stb, wr_stb;
  ctl_t ctl_q;
  logic [2:0] resume_q, ready_vis;
  logic rcs_q, sem_q;
  logic [31:0] ctl_word, sta_word, rd_mux;

  assign hit_ctl = (host_addr == ADDR_W'(OFS_CTL));
  assign hit_sta = (host_addr == ADDR_W'(OFS_STA));
  assign hit_sem = (host_addr == ADDR_W'(OFS_SEM));
  assign rd_stb  = host_sel && !host_wr;
  assign wr_stb  = host_sel && host_wr;

  alink_ctl_reg #(.WARM_CYCLES(WARM_CYCLES)) u_ctl (
    .clk(clk), .rst_n(rst_n), .wr_ctl(wr_stb && hit_ctl),
    .wdata(host_wdata[22:0]), .ctl_q(ctl_q));

  alink_stat_reg u_sta (
    .clk(clk), .rst_n(rst_n), .cold_rel(ctl_q.cold_rel),
    .resume_evt(resume_evt), .rd_done(rd_done),
    .clr_wr(wr_stb && hit_sta),
    .clr_resume({host_wdata[B_RSM2], host_wdata[B_RSM1], host_wdata[B_RSM0]}),
    .clr_rcs(host_wdata[B_RCS]),
    .resume_q(resume_q), .rcs_q(rcs_q));

  alink_sem u_sem (
    .clk(clk), .rst_n(rst_n), .cold_rel(ctl_q.cold_rel),
    .claim(rd_stb && hit_sem), .acc_done(acc_done), .sem_q(sem_q));

  assign ready_vis = codec_ready & {3{ctl_q.cold_rel}};

  always_comb begin
    ctl_word        = '0;
    ctl_word[0]     = ctl_q.gpi_en;
    ctl_word[1]     = ctl_q.cold_rel;
    ctl_word[2]     = ctl_q.warm;
    ctl_word[3]     = ctl_q.link_off;
    ctl_word[6:4]   = ctl_q.resume_en;
    ctl_word[21:20] = ctl_q.chan;
    ctl_word[22]    = ctl_q.wide;

    sta_word         = '0;
    sta_word[7:5]    = chan_irq[5:3];
    sta_word[2:0]    = chan_irq[2:0];
    sta_word[B_RDY0] = ready_vis[0];
    sta_word[B_RDY1] = ready_vis[1];
    sta_word[B_RDY2] = ready_vis[2];
    sta_word[B_RSM0] = resume_q[0];
    sta_word[B_RSM1] = resume_q[1];
    sta_word[B_RSM2] = resume_q[2];
    sta_word[B_RCS]  = rcs_q;
    sta_word[B_CAP4] = CAP_4CH;
    sta_word[B_CAP6] = CAP_6CH;

    if (hit_ctl)      rd_mux = ctl_word;
    else if (hit_sta) rd_mux = sta_word;
    else if (hit_sem) rd_mux = {31'b0, sem_q};
    else              rd_mux = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      host_rvalid <= 1'b0;
      host_rdata  <= '0;
    end else begin
      host_rvalid <= rd_stb;
      if (rd_stb) host_rdata <= rd_mux;
    end
  end

  assign cold_rst_n   = ctl_q.cold_rel;
  assign warm_rst     = ctl_q.warm;
  assign link_off     = ctl_q.link_off;
  assign chan_cfg     = ctl_q.chan;
  assign wide_samples = ctl_q.wide;
  assign irq = (|chan_irq[5:1]) | (chan_irq[0] & ctl_q.gpi_en) |
               (|(resume_q & ctl_q.resume_en));

  p_rvalid_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> host_rvalid);
  p_no_spurious_rvalid_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> !host_rvalid);
  p_ready_hidden_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !cold_rst_n |-> (sta_word[B_RDY0] == 1'b0 && sta_word[B_RDY2] == 1'b0));
endmodule

// File: tb/test_alink_global.sv
module test_alink_global;
  localparam int WARM = 16;
  localparam logic [31:0] CAPS = 32'h0010_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_sel = 1'b0, host_wr = 1'b0;
  logic [7:0] host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic host_rvalid;
  logic [31:0] host_rdata;
  logic [2:0] codec_ready = '0, resume_evt = '0;
  logic rd_done = 1'b0, acc_done = 1'b0;
  logic [5:0] chan_irq = '0;
  logic cold_rst_n, warm_rst, link_off, wide_samples, irq;
  logic [1:0] chan_cfg;

  int n_checks = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  alink_global #(.ADDR_W(8), .WARM_CYCLES(WARM)) i_alink_global (
    .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rvalid(host_rvalid),
    .host_rdata(host_rdata), .codec_ready(codec_ready), .resume_evt(resume_evt),
    .rd_done(rd_done), .acc_done(acc_done), .chan_irq(chan_irq),
    .cold_rst_n(cold_rst_n), .warm_rst(warm_rst), .link_off(link_off),
    .chan_cfg(chan_cfg), .wide_samples(wide_samples), .irq(irq));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    host_sel = 1'b1; host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_sel = 1'b0; host_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    host_sel = 1'b1; host_wr = 1'b0; host_addr = a;
    @(negedge clk);
    host_sel = 1'b0;
    check("R11 rvalid", {31'b0, host_rvalid}, 32'd1);
    d = host_rdata;
  endtask

  task automatic pulse_resume(input logic [2:0] m);
    @(negedge clk); resume_evt = m;
    @(negedge clk); resume_evt = '0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(8'h2C, d); check("R1 ctl", d, 32'h0);
    rd(8'h30, d); check("R1 sta", d, CAPS);
    rd(8'h34, d); check("R1 sem", d, 32'h0);
    check("R1 pins", {29'b0, cold_rst_n, warm_rst, irq}, 32'h0);
  endtask

  task automatic t_ready_gate;
    logic [31:0] d;
    codec_ready = 3'b111;
    pulse_resume(3'b111);
    rd(8'h30, d); check("R3 hidden in cold", d, CAPS);
    wr(8'h2C, 32'h2);
    check("R2 cold_rst_n", {31'b0, cold_rst_n}, 32'd1);
    rd(8'h30, d); check("R3 ready shown", d, CAPS | 32'h1000_0300);
    codec_ready = 3'b000;
  endtask

  task automatic t_resume_w1c;
    logic [31:0] d;
    pulse_resume(3'b101);
    rd(8'h30, d); check("R3 resume latched", d, CAPS | 32'h2000_0400);
    wr(8'h30, 32'h0000_0400);
    rd(8'h30, d); check("R4 w1c bit10", d, CAPS | 32'h2000_0000);
    wr(8'h30, 32'h2000_0000);
    // clear and set of bit 11 in the same cycle: set wins
    @(negedge clk);
    host_sel = 1'b1; host_wr = 1'b1; host_addr = 8'h30; host_wdata = 32'h800;
    resume_evt = 3'b010;
    @(negedge clk);
    host_sel = 1'b0; host_wr = 1'b0; resume_evt = '0;
    rd(8'h30, d); check("R4 set wins", d, CAPS | 32'h800);
    wr(8'h30, 32'h800);
    @(negedge clk); rd_done = 1'b1; @(negedge clk); rd_done = 1'b0;
    rd(8'h30, d); check("R4 rcs set", d, CAPS | 32'h8000);
    wr(8'h30, 32'h8000);
    rd(8'h30, d); check("R4 rcs cleared", d, CAPS);
  endtask

  task automatic t_warm;
    logic [31:0] d;
    int hi = 0;
    wr(8'h2C, 32'h6);
    while (warm_rst && hi < 100) begin hi++; @(negedge clk); end
    check("R5 warm width", hi, WARM);
    rd(8'h2C, d); check("R5 self clear", d, 32'h2);
    wr(8'h2C, 32'h0);
    wr(8'h2C, 32'h4);
    check("R5 ignored in cold", {31'b0, warm_rst}, 32'd0);
    wr(8'h2C, 32'h6);
    check("R5 ignored at release", {31'b0, warm_rst}, 32'd0);
    wr(8'h2C, 32'h6);
    check("R5 warm starts", {31'b0, warm_rst}, 32'd1);
    wr(8'h2C, 32'h2);
    check("R5 zero no effect", {31'b0, warm_rst}, 32'd1);
    wr(8'h2C, 32'h0);
    check("R2 cold aborts warm", {31'b0, warm_rst}, 32'd0);
    wr(8'h2C, 32'h2);
  endtask

  task automatic t_cfg;
    logic [31:0] d;
    wr(8'h2C, 32'h0050_0002);
    rd(8'h2C, d); check("R6 4ch 20bit", d, 32'h0050_0002);
    check("R6 pins", {29'b0, chan_cfg, wide_samples}, 32'h3);
    wr(8'h2C, 32'h0030_0002);
    rd(8'h2C, d); check("R6 reserved code", d, 32'h0010_0002);
    wr(8'h2C, 32'h00A0_0002);
    rd(8'h2C, d); check("R6 6ch bit23", d, 32'h0020_0002);
    wr(8'h2C, 32'h0000_007B);
    rd(8'h2C, d); check("R7 enables", d, 32'h7B);
    check("R7 link_off", {31'b0, link_off}, 32'd1);
    wr(8'h2C, 32'h2);
  endtask

  task automatic t_flags;
    logic [31:0] d;
    chan_irq = 6'b111111;
    rd(8'h30, d); check("R8 all flags", d, CAPS | 32'hE7);
    chan_irq = 6'b100001;
    rd(8'h30, d); check("R8 mic gpi", d, CAPS | 32'h81);
    chan_irq = 6'b010100;
    rd(8'h30, d); check("R8 pcmout modout", d, CAPS | 32'h44);
    chan_irq = '0;
  endtask

  task automatic t_sem;
    logic [31:0] d;
    rd(8'h34, d); check("R9 first claim", d, 32'd0);
    rd(8'h34, d); check("R9 held", d, 32'd1);
    @(negedge clk); acc_done = 1'b1; @(negedge clk); acc_done = 1'b0;
    rd(8'h34, d); check("R9 after done", d, 32'd0);
    @(negedge clk);
    host_sel = 1'b1; host_wr = 1'b0; host_addr = 8'h34; acc_done = 1'b1;
    @(negedge clk);
    host_sel = 1'b0; acc_done = 1'b0;
    check("R9 read with done", host_rdata, 32'd1);
    rd(8'h34, d); check("R9 cleared by done", d, 32'd0);
    wr(8'h2C, 32'h0);
    rd(8'h34, d); check("R9 cold clears", d, 32'd0);
    rd(8'h34, d); check("R9 no take in cold", d, 32'd0);
    wr(8'h2C, 32'h2);
  endtask

  task automatic t_irq;
    chan_irq = 6'b000001;
    @(negedge clk); check("R10 gpi masked", {31'b0, irq}, 32'd0);
    wr(8'h2C, 32'h3);
    check("R10 gpi enabled", {31'b0, irq}, 32'd1);
    chan_irq = '0;
    wr(8'h2C, 32'h12);
    pulse_resume(3'b001);
    check("R10 resume enabled", {31'b0, irq}, 32'd1);
    wr(8'h30, 32'h400);
    check("R10 resume cleared", {31'b0, irq}, 32'd0);
    pulse_resume(3'b010);
    check("R10 resume masked", {31'b0, irq}, 32'd0);
    wr(8'h30, 32'h800);
    chan_irq = 6'b010000;
    @(negedge clk); check("R10 pcm out", {31'b0, irq}, 32'd1);
    chan_irq = '0;
    wr(8'h2C, 32'h2);
  endtask

  task automatic t_decode;
    logic [31:0] d;
    wr(8'h38, 32'hFFFF_FFFF);
    rd(8'h38, d); check("R11 unmapped read", d, 32'h0);
    rd(8'h2C, d); check("R11 ctl untouched", d, 32'h2);
    rd(8'h30, d); check("R11 sta untouched", d, CAPS);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_ready_gate();
    t_resume_w1c();
    t_warm();
    t_cfg();
    t_flags();
    t_sem();
    t_irq();
    t_decode();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule